// File: doc/BRIEF.md
# Single-Cycle Stack and Data Memory Unit

This block pairs a byte-wide data memory with a stack pointer. It carries out four memory operations, each in one clock cycle: push, pop, indirect load and indirect store. Load and store take their address from a pointer made of two register-file bytes. Push and pop take it from the stack pointer. Memory writes happen on the clock edge. Reads are combinational, so a load or a pop returns its byte during the cycle in which it is issued.

The stack grows downward from the top address. A push writes at the current pointer and then moves the pointer down by one. A pop reads one address above the pointer and leaves the pointer at that address. A shadow register always holds the pointer plus one. A pop therefore reads memory straight from a register, and the address path contains a multiplexer but no adder.

Top module: `stkmem_unit`

## Requirements
- R1: After reset the stack pointer `sp_o` reads 0x3FF, the highest address of the 1024-byte memory.
- R2: A push writes `wdata_i` at address `sp_o` on the clock edge and leaves `sp_o` one lower. Push and pop must never be asserted in the same cycle.
- R3: A pop drives `rdata_o` in the same cycle with the byte at address `sp_o`+1, and `sp_o` becomes that address at the clock edge.
- R4: In a cycle without push or pop (idle, load or store), `sp_o` keeps its value.
- R5: The indirect address is 10 bits: `zlo_i` gives bits 7..0 and `zhi_i[1:0]` gives bits 9..8. Bits 7..2 of `zhi_i` have no effect.
- R6: A store writes `wdata_i` at the indirect address on the clock edge. A load drives `rdata_o` with the byte at the indirect address in the same cycle, including a byte stored in the cycle just before.
- R7: Pointer arithmetic wraps modulo 1024. A push at 0x000 moves the pointer to 0x3FF, and a pop at 0x3FF reads address 0x000 and moves the pointer to 0x000.
- R8: Pushes and pops in consecutive cycles, in any mix, need no idle cycle, and the pops return bytes in last-in first-out order.
- R9: `rdata_o` is 0 in every cycle in which neither load nor pop is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the pointer registers |
| push_i | input | 1 | Push `wdata_i` onto the stack this cycle |
| pop_i | input | 1 | Pop the top byte onto `rdata_o` this cycle |
| load_i | input | 1 | Read the byte at the indirect address onto `rdata_o` |
| store_i | input | 1 | Write `wdata_i` at the indirect address |
| wdata_i | input | 8 | Write data for push and store |
| zlo_i | input | 8 | Low byte of the indirect address |
| zhi_i | input | 8 | High byte of the indirect address; only bits 1..0 are used |
| rdata_o | output | 8 | Read data for load and pop; 0 otherwise |
| sp_o | output | 10 | Current stack pointer |

## Verification
The bench targets the pointer wrap at both ends. Popping straight out of reset must read address 0, and a design whose shadow register did not wrap would read a stale or out-of-range word there. Pushing at address 0 must land the pointer on 0x3FF. Alternating pushes and pops check that the shadow register tracks every pointer move. A shadow that lagged by one cycle would return the byte below the top of the stack. Loads with junk in the upper bits of the high pointer byte would reach the wrong byte if those bits leaked into the address. A load of a byte stored in the previous cycle catches read data that arrives a cycle late.

// File: rtl/stkmem_pkg.sv
package stkmem_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - DATA_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic {
    SEL_PTR   = 1'b0,
    SEL_STACK = 1'b1
  } addr_sel_e;

  localparam addr_t SP_RESET = addr_t'(DEPTH - 1);

  function automatic addr_t ptr_up(addr_t a);
    return a + addr_t'(1);
  endfunction

  function automatic addr_t ptr_down(addr_t a);
    return a - addr_t'(1);
  endfunction

  function automatic addr_t make_ptr(data_t lo, data_t hi);
    return {hi[HI_W-1:0], lo};
  endfunction
endpackage

// File: rtl/stkmem_sp.sv
module stkmem_sp
  import stkmem_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  output addr_t sp_q,
  output addr_t sp_plus_q,
  output addr_t stk_addr
);
  logic  move;
  addr_t sp_d, sp_plus_d;

  assign move = push | pop;

  always_comb begin
    sp_d      = sp_q;
    sp_plus_d = sp_plus_q;
    if (push) begin
      sp_d      = ptr_down(sp_q);
      sp_plus_d = sp_q;
    end else if (pop) begin
      sp_d      = sp_plus_q;
      sp_plus_d = ptr_up(sp_plus_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q      <= SP_RESET;
      sp_plus_q <= ptr_up(SP_RESET);
    end else if (move) begin
      sp_q      <= sp_d;
      sp_plus_q <= sp_plus_d;
    end
  end

  assign stk_addr = pop ? sp_plus_q : sp_q;

  // R2
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

  // R3
  shadow_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_plus_q == ptr_up(sp_q));

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == ptr_down($past(sp_q)));

  // R3
  pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> sp_q == ptr_up($past(sp_q)));

  // R4
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !move |=> $stable(sp_q));
endmodule

// File: rtl/stkmem_amux.sv
module stkmem_amux
  import stkmem_pkg::*;
(
  input  addr_sel_e sel,
  input  addr_t     ptr_addr,
  input  addr_t     stk_addr,
  output addr_t     mem_addr
);
  always_comb begin
    unique case (sel)
      SEL_STACK: mem_addr = stk_addr;
      default:   mem_addr = ptr_addr;
    endcase
  end
endmodule

// File: rtl/stkmem_ram.sv
module stkmem_ram
  import stkmem_pkg::*;
(
  input  logic  clk,
  input  logic  we,
  input  addr_t addr,
  input  data_t wdata,
  output data_t rdata
);
  data_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/stkmem_unit.sv
module stkmem_unit
  import stkmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic       pop_i,
  input  logic       load_i,
  input  logic       store_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] zlo_i,
  input  logic [7:0] zhi_i,
  output logic [7:0] rdata_o,
  output logic [9:0] sp_o
);
  addr_t     sp_q, sp_plus_q, stk_addr, ptr_addr, mem_addr;
  addr_sel_e addr_sel;
  logic      mem_we, read_en;
  data_t     mem_rd;

  assign ptr_addr = make_ptr(zlo_i, zhi_i);
  assign addr_sel = (push_i | pop_i) ? SEL_STACK : SEL_PTR;
  assign mem_we   = push_i | store_i;
  assign read_en  = pop_i | load_i;

  stkmem_sp u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_i),
    .pop       (pop_i),
    .sp_q      (sp_q),
    .sp_plus_q (sp_plus_q),
    .stk_addr  (stk_addr)
  );

  stkmem_amux u_amux (
    .sel      (addr_sel),
    .ptr_addr (ptr_addr),
    .stk_addr (stk_addr),
    .mem_addr (mem_addr)
  );

  stkmem_ram u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (wdata_i),
    .rdata (mem_rd)
  );

  assign rdata_o = read_en ? mem_rd : '0;
  assign sp_o    = sp_q;

  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> mem_addr == sp_o);

  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> mem_addr == ptr_up(sp_o));

  // R5
  ptr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i || store_i) && !push_i && !pop_i |-> mem_addr[7:0] == zlo_i);

  // R9
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i || load_i) |-> rdata_o == 8'h00);
endmodule

// File: tb/stkmem_unit_bench.sv
module stkmem_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, load_i = 1'b0, store_i = 1'b0;
  logic [7:0] wdata_i = '0, zlo_i = '0, zhi_i = '0;
  logic [7:0] rdata_o;
  logic [9:0] sp_o;

  int checks = 0;
  int failures = 0;
  int sp_m = 1023;
  int mem_m [int];
  bit done = 1'b0;

  always #10 clk = ~clk;

  stkmem_unit u_stkmem_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .load_i(load_i), .store_i(store_i), .wdata_i(wdata_i),
    .zlo_i(zlo_i), .zhi_i(zhi_i), .rdata_o(rdata_o), .sp_o(sp_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_i = 0; pop_i = 0; load_i = 0; store_i = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sp_m = 1023;
    #2 chk("R1 reset sp", sp_o, 1023);
  endtask

  // one cycle: drive at falling edge, compare, then advance the model
  task automatic step(input bit pu, input bit po, input bit ld, input bit st,
                      input int wd, input int zl, input int zh, input string req);
    int z, exp_rd;
    bit known;
    @(negedge clk);
    push_i = pu; pop_i = po; load_i = ld; store_i = st;
    wdata_i = 8'(wd); zlo_i = 8'(zl); zhi_i = 8'(zh);
    z = ((zh & 3) << 8) | (zl & 255);
    #2;
    chk({req, " sp"}, sp_o, sp_m);
    known = 1'b1;
    exp_rd = 0;
    if (po) begin
      known = mem_m.exists((sp_m + 1) % 1024);
      if (known) exp_rd = mem_m[(sp_m + 1) % 1024];
    end else if (ld) begin
      known = mem_m.exists(z);
      if (known) exp_rd = mem_m[z];
    end
    if (known) chk({req, " rdata"}, rdata_o, exp_rd);
    if (pu) begin
      mem_m[sp_m] = wd & 255;
      sp_m = (sp_m + 1023) % 1024;
    end else if (po) begin
      sp_m = (sp_m + 1) % 1024;
    end else if (st) begin
      mem_m[z] = wd & 255;
    end
  endtask

  task automatic idle_step(string req);
    step(0, 0, 0, 0, 8'hEE, 0, 0, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    idle_step("R9 idle");
    idle_step("R4 idle");

    // R6: store then load at several addresses, including the next cycle
    step(0, 0, 0, 1, 8'h11, 8'h00, 8'h00, "R6 store");
    step(0, 0, 1, 0, 0, 8'h00, 8'h00, "R6 load");
    step(0, 0, 0, 1, 8'hA5, 8'h34, 8'h02, "R6 store");
    step(0, 0, 1, 0, 0, 8'h34, 8'h02, "R6 load");
    step(0, 0, 0, 1, 8'h7C, 8'hFF, 8'h03, "R6 store");
    step(0, 0, 1, 0, 0, 8'hFF, 8'h03, "R6 load");
    // R5: junk in high bits of zhi is ignored on load and on store
    step(0, 0, 1, 0, 0, 8'h34, 8'hFE, "R5 load");
    step(0, 0, 0, 1, 8'h3C, 8'h10, 8'hA9, "R5 store");
    step(0, 0, 1, 0, 0, 8'h10, 8'h01, "R5 load");
    step(0, 0, 1, 0, 0, 8'hFF, 8'h5B, "R5 load");

    // R2 / R3: three pushes then three pops
    step(1, 0, 0, 0, 8'hC1, 0, 0, "R2 push");
    step(1, 0, 0, 0, 8'hC2, 0, 0, "R2 push");
    step(1, 0, 0, 0, 8'hC3, 0, 0, "R2 push");
    // R2: pushed byte visible at its address through an indirect load
    step(0, 0, 1, 0, 0, 8'hFD, 8'h03, "R2 push-load");
    step(0, 0, 1, 0, 0, 8'hFF, 8'h03, "R2 push-load");
    step(0, 0, 0, 1, 8'h99, 8'h20, 8'h00, "R4 store");
    step(0, 1, 0, 0, 0, 0, 0, "R3 pop");
    step(0, 1, 0, 0, 0, 0, 0, "R3 pop");
    step(0, 1, 0, 0, 0, 0, 0, "R3 pop");
    idle_step("R4 idle");

    // R8: interleaved push/pop back to back
    step(1, 0, 0, 0, 8'h51, 0, 0, "R8 push");
    step(0, 1, 0, 0, 0, 0, 0, "R8 pop");
    step(1, 0, 0, 0, 8'h52, 0, 0, "R8 push");
    step(1, 0, 0, 0, 8'h53, 0, 0, "R8 push");
    step(0, 1, 0, 0, 0, 0, 0, "R8 pop");
    step(1, 0, 0, 0, 8'h54, 0, 0, "R8 push");
    step(0, 1, 0, 0, 0, 0, 0, "R8 pop");
    step(0, 1, 0, 0, 0, 0, 0, "R8 pop");
    idle_step("R8 end");

    // R7: wrap at the bottom of the address range
    step(0, 0, 0, 1, 8'h5A, 8'h00, 8'h00, "R7 store0");
    do_reset();
    step(0, 1, 0, 0, 0, 0, 0, "R7 pop wrap");
    step(1, 0, 0, 0, 8'h6B, 0, 0, "R7 push at 0");
    step(0, 0, 1, 0, 0, 8'h00, 8'h00, "R7 load0");
    step(0, 1, 0, 0, 0, 0, 0, "R7 pop");
    idle_step("R7 end");

    // mixed sequence, model compared on every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int op;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = lfsr[2:0] % 5;
      case (op)
        0: step(1, 0, 0, 0, lfsr[15:8], 0, 0, "R8 mix push");
        1: step(0, 1, 0, 0, 0, 0, 0, "R8 mix pop");
        2: step(0, 0, 0, 1, lfsr[7:0], lfsr[15:8], lfsr[11:4], "R6 mix store");
        3: step(0, 0, 1, 0, 0, lfsr[15:8], lfsr[11:4], "R6 mix load");
        default: idle_step("R9 mix idle");
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule